// File: doc/BRIEF.md
# Cartridge Unlock Sequence Mapper

This block sits on the write side of a cartridge bus and watches every halfword write. Its control registers are hidden behind a long fixed pattern of address/data writes. Several steps of that pattern must be repeated an exact number of times. When the whole pattern has been seen, the next write is taken as one command. That command can lift the flash write protection, pick which 64 KB SRAM bank is visible, or load the flash base-offset register.

The block drives the protection state, the SRAM bank number, the stored offset register, and the flash address bits 24..15 that the offset register implies. Any write that breaks the pattern sends the recogniser back to its idle state. Bus timing, the flash device and the SRAM array are outside this block.

The bus address is a byte address, so each logical command address appears on the bus shifted left by one. The exact repeat count, the number of SRAM banks and a reduced offset-register variant are build parameters.

Top module: `cart_unlock_mapper`

## Requirements
- R1: While `rst_n` is low at a clock edge, `flash_wp` becomes 1 and `sram_bank`, `flash_offset` and `flash_base_hi` become 0.
- R2: A write matches a logical address A only when `bus_addr` equals A shifted left by one with bit 0 clear. A write whose address has bit 0 set, or that carries A unshifted, breaks the pattern.
- R3: The unlock pattern has eleven steps, taken in this order as (logical address, data) × count: (987654h,5354h)×1, (012345h,1234h)×N, (007654h,5354h)×1, (012345h,5354h)×1, (012345h,5678h)×N, (987654h,5354h)×1, (012345h,5354h)×1, (765400h,5678h)×1, (013450h,1234h)×1, (012345h,ABCDh)×N, (987654h,5354h)×1. N is `REP_COUNT`. After the pattern, a command write of 9413h to F12345h sets `flash_wp` to 0.
- R4: If a repeated step receives fewer than N writes before the next step's write arrives, the pattern is aborted and the following command has no effect.
- R5: If a repeated step receives more than N matching writes, the pattern is aborted and the following command has no effect.
- R6: A write with the wrong address or the wrong data at any step aborts the pattern and is discarded. A complete pattern sent afterwards unlocks normally.
- R7: A command write to A12345h loads `sram_bank` from data bits 2:0, masked to log2(`SRAM_BANKS`) bits. With 4 banks, bit 2 reads 0.
- R8: A command write to B5AC97h loads `flash_offset` from data bits 9:0; data bits 15:10 are ignored. `flash_base_hi` (address bits 24..15) is the sum of the set offset bits' weights, shifted right by 15. The weights are: bit0 4 MB, bit1 8 MB, bit2 16 MB, bit3 32 KB, bit4 64 KB, bit5 128 KB, bit6 256 KB, bit7 512 KB, bit8 1 MB, bit9 2 MB.
- R9: With `LEGACY_OFFSET`=1, only offset bits 0, 1 and 3 are stored, and the others read as 0 (mask 00Bh).
- R10: Each completed pattern admits exactly one command write. A second command write without a fresh pattern changes nothing.
- R11: A write of any value other than 9413h to F12345h in the command slot leaves `flash_wp` unchanged. A command-slot write to any other address changes no output and still uses up the unlock.
- R12: Outputs change only on the clock edge that samples the accepted command write. The pattern writes themselves leave all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | One halfword write is presented this cycle |
| bus_addr | input | 25 | Byte address of the write |
| bus_wdata | input | 16 | Write data |
| flash_wp | output | 1 | 1 = flash writes blocked |
| sram_bank | output | 3 | Selected 64 KB SRAM bank |
| flash_offset | output | 10 | Stored flash base-offset register |
| flash_base_hi | output | 10 | Flash address bits 24..15 implied by the offset |

## Verification
Two functions share the last cycle of the pattern. The final pattern write arms the command slot, and the write that follows is decoded as a command rather than being matched against the pattern. A pattern-start write that lands in that slot must therefore be consumed as an unknown command, not taken as the first step of a new pattern. The bench provokes this overlap in several ways: it sends a second command straight after an accepted one, it places non-command data in the slot and then sends a real command, and it ends short and over-long repeat runs exactly at a step boundary. In each case it judges the outcome only at the outputs, by checking that the bank or protection state stays at its prior value on the edge after the command write.

// File: rtl/cum_pkg.sv
// Package for the cartridge unlock mapper.
// Holds the unlock step table (computed by a function, not stored as a memory),
// the command addresses and keys, and the shared widths.
// Assumes a 25-bit byte-addressed bus that carries 24-bit logical halfword addresses.
package cum_pkg;

    localparam int BUS_AW  = 25;   // byte address width on the bus
    localparam int LOG_AW  = 24;   // logical (halfword) address width
    localparam int DATA_W  = 16;
    localparam int OFFS_W  = 10;   // flash offset register width
    localparam int STEP_N  = 11;   // number of unlock steps

    localparam logic [LOG_AW-1:0] CMD_WP_ADDR   = 24'hF12345;
    localparam logic [DATA_W-1:0] WP_KEY        = 16'h9413;
    localparam logic [LOG_AW-1:0] CMD_BANK_ADDR = 24'hA12345;
    localparam logic [LOG_AW-1:0] CMD_OFFS_ADDR = 24'hB5AC97;

    typedef struct packed {
        logic [LOG_AW-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              rep;   // 1 = step repeats REP_COUNT times
    } step_t;

    // Returns the expected write of unlock step idx; out-of-range gives zeros.
    function automatic step_t step_at(input int idx);
        step_t s;
        s = '{addr: '0, data: '0, rep: 1'b0};
        case (idx)
            0:  s = '{addr: 24'h987654, data: 16'h5354, rep: 1'b0};
            1:  s = '{addr: 24'h012345, data: 16'h1234, rep: 1'b1};
            2:  s = '{addr: 24'h007654, data: 16'h5354, rep: 1'b0};
            3:  s = '{addr: 24'h012345, data: 16'h5354, rep: 1'b0};
            4:  s = '{addr: 24'h012345, data: 16'h5678, rep: 1'b1};
            5:  s = '{addr: 24'h987654, data: 16'h5354, rep: 1'b0};
            6:  s = '{addr: 24'h012345, data: 16'h5354, rep: 1'b0};
            7:  s = '{addr: 24'h765400, data: 16'h5678, rep: 1'b0};
            8:  s = '{addr: 24'h013450, data: 16'h1234, rep: 1'b0};
            9:  s = '{addr: 24'h012345, data: 16'hABCD, rep: 1'b1};
            10: s = '{addr: 24'h987654, data: 16'h5354, rep: 1'b0};
            default: s = '{addr: '0, data: '0, rep: 1'b0};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/cum_unlock_seq.sv
// Unlock pattern recogniser.
// Tracks the current step and how many matching writes that step has received.
// Once a step has its full count, the next write must match the following step.
// Any other write returns to idle and is discarded. Completing the last step
// arms a one-write command slot; the write in that slot is passed out as
// cmd_fire, and the recogniser then returns to idle.
// Assumes REP_COUNT >= 1 and that the last step is a single write.
module cum_unlock_seq
    import cum_pkg::*;
#(
    parameter int REP_COUNT = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BUS_AW-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              armed,
    output logic              cmd_fire
);

    localparam int CNT_W  = $clog2(REP_COUNT + 1);
    localparam int STEP_W = $clog2(STEP_N);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEP_N - 1);
    localparam logic [STEP_W-1:0] PRE_LAST  = STEP_W'(STEP_N - 2);

    logic [STEP_W-1:0] step_q, step_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              armed_d;
    step_t             cur, nxt;
    logic [CNT_W-1:0]  need_cur;
    logic              hit_cur, hit_nxt, cur_done;

    // Look up the current and following step and compare them with the bus.
    always_comb begin
        cur      = step_at(int'(step_q));
        nxt      = step_at(int'(step_q) + 1);
        need_cur = cur.rep ? CNT_W'(REP_COUNT) : CNT_W'(1);
        hit_cur  = (addr == {cur.addr, 1'b0}) && (data == cur.data);
        hit_nxt  = (addr == {nxt.addr, 1'b0}) && (data == nxt.data);
        cur_done = (cnt_q == need_cur);
    end

    // Next-state rule for step, count and the command slot.
    always_comb begin
        step_d  = step_q;
        cnt_d   = cnt_q;
        armed_d = armed;
        if (we) begin
            if (armed) begin
                armed_d = 1'b0;
                step_d  = '0;
                cnt_d   = '0;
            end else if (!cur_done) begin
                if (hit_cur) begin
                    cnt_d = cnt_q + 1'b1;
                    if ((step_q == LAST_STEP) && (cnt_q + 1'b1 == need_cur)) begin
                        armed_d = 1'b1;
                        step_d  = '0;
                        cnt_d   = '0;
                    end
                end else begin
                    step_d = '0;
                    cnt_d  = '0;
                end
            end else if ((step_q != LAST_STEP) && hit_nxt) begin
                step_d = step_q + 1'b1;
                cnt_d  = CNT_W'(1);
                if (step_q == PRE_LAST) begin
                    armed_d = 1'b1;
                    step_d  = '0;
                    cnt_d   = '0;
                end
            end else begin
                step_d = '0;
                cnt_d  = '0;
            end
        end
    end

    // State registers with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            cnt_q  <= '0;
            armed  <= 1'b0;
        end else begin
            step_q <= step_d;
            cnt_q  <= cnt_d;
            armed  <= armed_d;
        end
    end

    // The write in the armed slot is the command.
    assign cmd_fire = we && armed;

    // R5: a step never holds more writes than its count.
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= need_cur);

    // R10: the command slot closes after the one write it admits.
    a_r10_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && we) |=> !armed);

    // R3: the slot opens only as a result of a bus write.
    a_r3_arm_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(we));

    // R6: while armed, no pattern progress is held.
    a_r6_idle_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (step_q == '0) && (cnt_q == '0));

endmodule

// File: rtl/cum_cmd_decode.sv
// Command decoder and control registers.
// On a command write it updates the write-protect flag, the SRAM bank or the
// flash offset register. In the reduced variant only offset bits 0, 1 and 3
// get flops; the rest are tied to zero.
// Assumes cmd_fire is high for exactly the one accepted command write.
module cum_cmd_decode
    import cum_pkg::*;
#(
    parameter int SRAM_BANKS    = 8,
    parameter bit LEGACY_OFFSET = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_fire,
    input  logic [BUS_AW-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              flash_wp,
    output logic [2:0]        sram_bank,
    output logic [OFFS_W-1:0] flash_offset
);

    localparam int BANK_W = $clog2(SRAM_BANKS);
    localparam logic [2:0] BANK_MASK = 3'((1 << BANK_W) - 1);
    localparam logic [OFFS_W-1:0] KEEP = LEGACY_OFFSET ? 10'h00B : 10'h3FF;

    logic hit_wp, hit_bank, hit_offs;

    // Decode which command, if any, this write carries.
    always_comb begin
        hit_wp   = cmd_fire && (addr == {CMD_WP_ADDR, 1'b0}) && (data == WP_KEY);
        hit_bank = cmd_fire && (addr == {CMD_BANK_ADDR, 1'b0});
        hit_offs = cmd_fire && (addr == {CMD_OFFS_ADDR, 1'b0});
    end

    // Write-protect flag: set by reset, cleared by the key command.
    always_ff @(posedge clk) begin
        if (!rst_n)      flash_wp <= 1'b1;
        else if (hit_wp) flash_wp <= 1'b0;
    end

    // SRAM bank register, masked to the implemented bank count.
    always_ff @(posedge clk) begin
        if (!rst_n)        sram_bank <= '0;
        else if (hit_bank) sram_bank <= data[2:0] & BANK_MASK;
    end

    // Offset register: one flop per implemented bit, constant zero otherwise.
    for (genvar i = 0; i < OFFS_W; i++) begin : g_offs
        if (KEEP[i]) begin : g_keep
            logic bit_q;
            // Holds offset bit i.
            always_ff @(posedge clk) begin
                if (!rst_n)        bit_q <= 1'b0;
                else if (hit_offs) bit_q <= data[i];
            end
            assign flash_offset[i] = bit_q;
        end else begin : g_tie
            assign flash_offset[i] = 1'b0;
        end
    end

    // R3: the key command clears protection on the next edge.
    a_r3_wp_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && (addr == {CMD_WP_ADDR, 1'b0}) && (data == WP_KEY)) |=> !flash_wp);

    // R11: protection never changes without the key command.
    a_r11_wp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_fire && (data == WP_KEY)) |=> $stable(flash_wp));

    // R7: a bank command lands the masked data bits.
    a_r7_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && (addr == {CMD_BANK_ADDR, 1'b0})) |=> sram_bank == ($past(data[2:0]) & BANK_MASK));

    // R12: bank and offset hold on every edge that carries no command.
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_fire |=> $stable(sram_bank) && $stable(flash_offset));

    // R9: bits not implemented in the reduced variant stay zero.
    a_r9_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_offset & ~KEEP) == '0);

endmodule

// File: rtl/cum_offset_map.sv
// Offset-to-address remapper.
// Turns the scattered offset register into flash address bits 24..15.
// Register bits 3..9 weigh 32 KB..2 MB (address bits 15..21), and register
// bits 0..2 weigh 4, 8 and 16 MB (address bits 22..24). Purely combinational.
module cum_offset_map
    import cum_pkg::*;
(
    input  logic [OFFS_W-1:0] offs,
    output logic [OFFS_W-1:0] base_hi
);

    // Route each address bit from its register bit.
    for (genvar i = 0; i < OFFS_W; i++) begin : g_map
        localparam int SRC = (i < 7) ? i + 3 : i - 7;
        assign base_hi[i] = offs[SRC];
    end

endmodule

// File: rtl/cart_unlock_mapper.sv
// Top of the cartridge unlock mapper.
// Joins the pattern recogniser, the command decoder and the offset remapper.
// Assumes one bus write per cycle at most, presented with bus_we high.
module cart_unlock_mapper
    import cum_pkg::*;
#(
    parameter int REP_COUNT     = 500,
    parameter int SRAM_BANKS    = 8,
    parameter bit LEGACY_OFFSET = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_we,
    input  logic [24:0]                bus_addr,
    input  logic [15:0]                bus_wdata,
    output logic                       flash_wp,
    output logic [2:0]                 sram_bank,
    output logic [9:0]                 flash_offset,
    output logic [9:0]                 flash_base_hi
);

    logic armed;
    logic cmd_fire;

    cum_unlock_seq #(.REP_COUNT(REP_COUNT)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (bus_we),
        .addr     (bus_addr),
        .data     (bus_wdata),
        .armed    (armed),
        .cmd_fire (cmd_fire)
    );

    cum_cmd_decode #(.SRAM_BANKS(SRAM_BANKS), .LEGACY_OFFSET(LEGACY_OFFSET)) u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_fire     (cmd_fire),
        .addr         (bus_addr),
        .data         (bus_wdata),
        .flash_wp     (flash_wp),
        .sram_bank    (sram_bank),
        .flash_offset (flash_offset)
    );

    cum_offset_map u_map (
        .offs    (flash_offset),
        .base_hi (flash_base_hi)
    );

endmodule

// File: tb/test_cart_unlock_mapper.sv
// Bench: a full instance and a reduced instance (4 banks, legacy offset) share
// one bus. Repeat count is 3, so every step, count boundary and command can be swept.
module test_cart_unlock_mapper;

    localparam int REP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [24:0] addr = '0;
    logic [15:0] data = '0;

    logic       wp_a, wp_b;
    logic [2:0] bank_a, bank_b;
    logic [9:0] off_a, off_b, base_a, base_b;

    int checks = 0;
    int errors = 0;

    logic       e_wp;
    logic [2:0] e_bank;
    logic [9:0] e_off;

    always #4 clk = ~clk;

    cart_unlock_mapper #(.REP_COUNT(REP), .SRAM_BANKS(8), .LEGACY_OFFSET(1'b0)) i_cart_unlock_mapper (
        .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(data),
        .flash_wp(wp_a), .sram_bank(bank_a), .flash_offset(off_a), .flash_base_hi(base_a));

    cart_unlock_mapper #(.REP_COUNT(REP), .SRAM_BANKS(4), .LEGACY_OFFSET(1'b1)) i_cart_unlock_mapper_legacy (
        .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(data),
        .flash_wp(wp_b), .sram_bank(bank_b), .flash_offset(off_b), .flash_base_hi(base_b));

    function automatic logic [23:0] st_addr(input int k);
        case (k)
            0, 5, 10:       return 24'h987654;
            1, 3, 4, 6, 9:  return 24'h012345;
            2:              return 24'h007654;
            7:              return 24'h765400;
            default:        return 24'h013450;
        endcase
    endfunction

    function automatic logic [15:0] st_data(input int k);
        case (k)
            0, 2, 3, 5, 6, 10: return 16'h5354;
            1, 8:              return 16'h1234;
            4, 7:              return 16'h5678;
            default:           return 16'hABCD;
        endcase
    endfunction

    function automatic int need(input int k);
        return (k == 1 || k == 4 || k == 9) ? REP : 1;
    endfunction

    // Address bits 24..15 from the weighted sum of offset bits (R8).
    function automatic logic [9:0] exp_base(input logic [9:0] o);
        longint a = 0;
        if (o[0]) a += 64'd4 << 20;
        if (o[1]) a += 64'd8 << 20;
        if (o[2]) a += 64'd16 << 20;
        if (o[3]) a += 64'd32 << 10;
        if (o[4]) a += 64'd64 << 10;
        if (o[5]) a += 64'd128 << 10;
        if (o[6]) a += 64'd256 << 10;
        if (o[7]) a += 64'd512 << 10;
        if (o[8]) a += 64'd1 << 20;
        if (o[9]) a += 64'd2 << 20;
        return 10'(a >> 15);
    endfunction

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "wp",          int'(wp_a),   int'(e_wp));
        chk(req, "bank",        int'(bank_a), int'(e_bank));
        chk(req, "offset",      int'(off_a),  int'(e_off));
        chk(req, "base",        int'(base_a), int'(exp_base(e_off)));
        chk(req, "legacy wp",   int'(wp_b),   int'(e_wp));
        chk(req, "legacy bank", int'(bank_b), int'(e_bank & 3'd3));
        chk(req, "legacy off",  int'(off_b),  int'(e_off & 10'h00B));
        chk(req, "legacy base", int'(base_b), int'(exp_base(e_off & 10'h00B)));
    endtask

    task automatic wr_raw(input logic [24:0] a, input logic [15:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; data = d;
        @(negedge clk);
        we = 1'b0; addr = '0; data = '0;
    endtask

    task automatic wr(input logic [23:0] la, input logic [15:0] d);
        wr_raw({la, 1'b0}, d);
    endtask

    // Full pattern; step tk receives need+delta writes.
    task automatic unlock(input int tk, input int delta);
        for (int k = 0; k < 11; k++) begin
            int n = need(k) + ((k == tk) ? delta : 0);
            for (int j = 0; j < n; j++) wr(st_addr(k), st_data(k));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        e_wp = 1'b1; e_bank = '0; e_off = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        check_all("R1");

        // R12: the pattern alone leaves outputs alone; R3: key command clears protection
        unlock(-1, 0);
        check_all("R12");
        wr(24'hF12345, 16'h9413);
        e_wp = 1'b0;
        check_all("R3");

        // R1: reset again restores protection
        do_reset();
        check_all("R1");

        // R11: wrong key leaves protection set
        unlock(-1, 0);
        wr(24'hF12345, 16'h9412);
        check_all("R11");
        // R11: unknown command address consumes the unlock
        unlock(-1, 0);
        wr(24'h123456, 16'h0005);
        wr(24'hA12345, 16'h0005);
        check_all("R11");

        // R7: sweep every bank, junk in upper data bits
        for (int b = 0; b < 8; b++) begin
            unlock(-1, 0);
            wr(24'hA12345, 16'hABC0 | 16'(b));
            e_bank = 3'(b);
            check_all("R7");
        end

        // R8/R9: walk each offset bit, junk in bits 15:10
        for (int i = 0; i < 10; i++) begin
            unlock(-1, 0);
            wr(24'hB5AC97, 16'hFC00 | (16'd1 << i));
            e_off = 10'd1 << i;
            check_all("R8");
        end
        unlock(-1, 0);
        wr(24'hB5AC97, 16'h03FF);
        e_off = 10'h3FF;
        check_all("R9");
        unlock(-1, 0);
        wr(24'hB5AC97, 16'h02A5);
        e_off = 10'h2A5;
        check_all("R8");

        // R10: second command without a new pattern
        unlock(-1, 0);
        wr(24'hA12345, 16'h0002);
        e_bank = 3'd2;
        wr(24'hA12345, 16'h0006);
        check_all("R10");

        // R4 and R5: short and long runs on each repeated step
        for (int t = 0; t < 3; t++) begin
            int tk = (t == 0) ? 1 : (t == 1) ? 4 : 9;
            unlock(tk, -1);
            wr(24'hA12345, 16'h0007);
            check_all("R4");
            unlock(tk, 1);
            wr(24'hA12345, 16'h0007);
            check_all("R5");
        end

        // R6: wrong data, then wrong address, at each step
        for (int k = 0; k < 11; k++) begin
            for (int v = 0; v < 2; v++) begin
                for (int s = 0; s < k; s++)
                    for (int j = 0; j < need(s); j++) wr(st_addr(s), st_data(s));
                if (v == 0) wr(st_addr(k), st_data(k) ^ 16'h0100);
                else        wr(st_addr(k) ^ 24'h000100, st_data(k));
                wr(24'hA12345, 16'h0007);
                check_all("R6");
            end
        end
        // R6: a clean pattern after aborts still works
        unlock(-1, 0);
        wr(24'hA12345, 16'h0003);
        e_bank = 3'd3;
        check_all("R6");

        // R2: bit 0 set, and unshifted address, at step 5
        for (int v = 0; v < 2; v++) begin
            for (int k = 0; k < 11; k++) begin
                if (k == 5) begin
                    if (v == 0) wr_raw({st_addr(5), 1'b1}, st_data(5));
                    else        wr_raw({1'b0, st_addr(5)}, st_data(5));
                end else begin
                    for (int j = 0; j < need(k); j++) wr(st_addr(k), st_data(k));
                end
            end
            wr(24'hA12345, 16'h0006);
            check_all("R2");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule